// File: doc/BRIEF.md
# Stack ALU with incremental carry

This block is the top-of-stack execution unit of a small stack processor. Three function units run all the time on the current top (TOS) and second (SOS) stack entries: a bitwise AND, an XOR and a complement. A stateful adder runs alongside them. Each instruction slot presents a 3-bit opcode with a valid strobe. The opcode does not start any work. It picks one of the results that are already computed, loads it into TOS, and applies the stack effect that belongs to that opcode. Entries below SOS sit in an 8-entry circular buffer, and the pointer into that buffer is brought out as the depth view.

The adder is slow on purpose. Whenever the stack changes, it reloads with a partial sum and a vector of pending carries. On every cycle in which the stack stays still, those carries ripple four bit positions further up. An add instruction takes the partial sum exactly as it stands at that moment. Code therefore has to place enough nop slots before an add, five for the default 20-bit width, to get the exact result.

Top module: `stk_alu`

## Requirements
- R1: A synchronous active-high reset clears TOS, SOS, every buffer entry, the buffer pointer and the adder state to zero. An add issued straight after reset therefore yields 0.
- R2: A cycle with the valid strobe low, or with opcode 0 (nop), leaves TOS, SOS and the pointer unchanged.
- R3: Opcode 1 (dup) moves TOS into SOS and pushes the old SOS into the buffer slot at pointer+1. The pointer then increments and TOS keeps its value.
- R4: Opcode 2 writes TOS AND SOS into TOS, and opcode 3 writes TOS XOR SOS into TOS. Each of them pops: SOS is refilled from the buffer slot at the pointer, and the pointer decrements.
- R5: Opcode 4 writes the bitwise complement of TOS into TOS and leaves SOS and the pointer unchanged.
- R6: Any cycle that writes TOS or moves the pointer reloads the adder from the new TOS and SOS. The partial sum becomes TOS XOR SOS, and the carries become (TOS AND SOS) shifted left by one.
- R7: In every cycle without a stack change, the adder performs 4 ripple steps. Each step computes sum' = sum XOR carry and carry' = (sum AND carry) << 1. After 5 such cycles the carries are zero and the partial sum equals TOS+SOS mod 2^20.
- R8: Opcode 5 (add) writes the current partial sum into TOS, whether or not it has settled, and pops SOS.
- R9: Opcode 6 (conditional add) writes the partial sum into TOS only when bit 0 of TOS is 1, and never pops. When bit 0 is 0 it acts as a nop and the carries keep propagating.
- R10: Opcode 7 is reserved. It behaves exactly like nop.
- R11: Pushes and pops wrap the pointer modulo 8 without any error. Nine dups from reset leave the pointer at 1.
- R12: In every cycle, partial sum + carries equals TOS + SOS mod 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode strobe for this slot |
| opcode | input | 3 | Instruction selector |
| tos | output | 20 | Top of stack |
| sos | output | 20 | Second of stack |
| depth_ptr | output | 3 | Circular buffer pointer |

## Verification
Several properties are checked on every cycle. The partial sum plus the pending carries must always equal TOS+SOS. The carries must have drained once five quiet cycles have passed since the last change. The idle and reserved opcodes, and a conditional add, must leave the stack as they found it. AND, complement and dup must produce their results one cycle later. The value that an early add actually returns, after zero or one nop, can only be shown by the bench's scenarios. The same holds for the wrap of the buffer after nine pushes and for the adder being cleared by reset.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_DUP  = 3'd1,
        OP_AND  = 3'd2,
        OP_XOR  = 3'd3,
        OP_INV  = 3'd4,
        OP_ADD  = 3'd5,
        OP_ADDC = 3'd6,
        OP_RSV  = 3'd7
    } opcode_e;

    typedef enum logic [2:0] {
        SEL_KEEP = 3'd0,
        SEL_AND  = 3'd1,
        SEL_XOR  = 3'd2,
        SEL_INV  = 3'd3,
        SEL_SUM  = 3'd4
    } sel_e;

    typedef struct packed {
        logic wr_tos;
        sel_e sel;
        logic push;
        logic pop;
    } ctrl_t;

    // Map one instruction slot to its TOS source and stack effect.
    function automatic ctrl_t op_decode(logic valid, opcode_e op, logic tos_lsb);
        ctrl_t c;
        c.wr_tos = 1'b0;
        c.sel    = SEL_KEEP;
        c.push   = 1'b0;
        c.pop    = 1'b0;
        if (valid) begin
            case (op)
                OP_DUP:  c.push = 1'b1;
                OP_AND:  begin c.wr_tos = 1'b1; c.sel = SEL_AND; c.pop = 1'b1; end
                OP_XOR:  begin c.wr_tos = 1'b1; c.sel = SEL_XOR; c.pop = 1'b1; end
                OP_INV:  begin c.wr_tos = 1'b1; c.sel = SEL_INV; end
                OP_ADD:  begin c.wr_tos = 1'b1; c.sel = SEL_SUM; c.pop = 1'b1; end
                OP_ADDC: begin
                    if (tos_lsb) begin
                        c.wr_tos = 1'b1;
                        c.sel    = SEL_SUM;
                    end
                end
                default: ;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/stk_decode.sv
module stk_decode
    import stk_pkg::*;
(
    input  logic        op_valid,
    input  logic [2:0]  opcode,
    input  logic        tos_lsb,
    output ctrl_t       ctrl,
    output logic        change
);
    always_comb begin
        ctrl   = op_decode(op_valid, opcode_e'(opcode), tos_lsb);
        change = ctrl.wr_tos | ctrl.push | ctrl.pop;
    end
endmodule

// File: rtl/stk_units.sv
module stk_units
    import stk_pkg::*;
#(
    parameter int DW = 20
) (
    input  logic [DW-1:0] tos_i,
    input  logic [DW-1:0] sos_i,
    input  logic [DW-1:0] sum_i,
    input  sel_e          sel,
    output logic [DW-1:0] result
);
    logic [DW-1:0] and_r, xor_r, inv_r;

    // All units evaluate every cycle; the opcode only selects.
    always_comb begin
        and_r = tos_i & sos_i;
        xor_r = tos_i ^ sos_i;
        inv_r = ~tos_i;
        case (sel)
            SEL_AND: result = and_r;
            SEL_XOR: result = xor_r;
            SEL_INV: result = inv_r;
            SEL_SUM: result = sum_i;
            default: result = tos_i;
        endcase
    end
endmodule

// File: rtl/stk_adder.sv
module stk_adder #(
    parameter int DW    = 20,
    parameter int CSTEP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] a_n,
    input  logic [DW-1:0] b_n,
    output logic [DW-1:0] sum_o,
    output logic [DW-1:0] carry_o
);
    localparam int FULL = (DW + CSTEP - 1) / CSTEP;
    localparam int CW   = $clog2(FULL + 1);

    logic [DW-1:0] ps_q, cy_q;
    logic [DW-1:0] ps_w [CSTEP+1];
    logic [DW-1:0] cy_w [CSTEP+1];
    logic [DW-1:0] gen_w;

    assign ps_w[0] = ps_q;
    assign cy_w[0] = cy_q;
    assign gen_w   = a_n & b_n;

    // CSTEP ripple stages per clock.
    for (genvar g = 0; g < CSTEP; g++) begin : g_rip
        assign ps_w[g+1] = ps_w[g] ^ cy_w[g];
        assign cy_w[g+1] = {ps_w[g][DW-2:0] & cy_w[g][DW-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_q <= '0;
            cy_q <= '0;
        end else if (load) begin
            ps_q <= a_n ^ b_n;
            cy_q <= {gen_w[DW-2:0], 1'b0};
        end else begin
            ps_q <= ps_w[CSTEP];
            cy_q <= cy_w[CSTEP];
        end
    end

    assign sum_o   = ps_q;
    assign carry_o = cy_q;

    // Quiet-cycle counter for the drain check.
    logic [CW-1:0] quiet_q;
    always_ff @(posedge clk) begin
        if (rst)                            quiet_q <= CW'(FULL);
        else if (load)                      quiet_q <= '0;
        else if (quiet_q < CW'(FULL))       quiet_q <= quiet_q + 1'b1;
    end

    AST_CARRY_DRAINED: assert property (@(posedge clk) disable iff (rst)
        (quiet_q == CW'(FULL)) |-> (cy_q == '0)); // R7
endmodule

// File: rtl/stk_store.sv
module stk_store
    import stk_pkg::*;
#(
    parameter int DW    = 20,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  ctrl_t                    ctrl,
    input  logic [DW-1:0]            result,
    output logic [DW-1:0]            tos_q,
    output logic [DW-1:0]            sos_q,
    output logic [$clog2(DEPTH)-1:0] ptr_q,
    output logic [DW-1:0]            tos_nxt,
    output logic [DW-1:0]            sos_nxt
);
    localparam int PW = $clog2(DEPTH);

    logic [DW-1:0] ring_q [DEPTH];
    logic [PW-1:0] ptr_nxt, ptr_up;

    assign ptr_up = ptr_q + 1'b1;

    always_comb begin
        tos_nxt = ctrl.wr_tos ? result : tos_q;
        sos_nxt = sos_q;
        ptr_nxt = ptr_q;
        if (ctrl.push) begin
            sos_nxt = tos_q;
            ptr_nxt = ptr_up;
        end else if (ctrl.pop) begin
            sos_nxt = ring_q[ptr_q];
            ptr_nxt = ptr_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tos_q <= '0;
            sos_q <= '0;
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) ring_q[i] <= '0;
        end else begin
            tos_q <= tos_nxt;
            sos_q <= sos_nxt;
            ptr_q <= ptr_nxt;
            if (ctrl.push) ring_q[ptr_up] <= sos_q;
        end
    end

    AST_DUP_COPY: assert property (@(posedge clk) disable iff (rst)
        ctrl.push |=> (tos_q == sos_q) && (ptr_q == $past(ptr_q) + 1'b1)); // R3
endmodule

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
#(
    parameter int DW    = 20,
    parameter int CSTEP = 4,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     op_valid,
    input  logic [2:0]               opcode,
    output logic [DW-1:0]            tos,
    output logic [DW-1:0]            sos,
    output logic [$clog2(DEPTH)-1:0] depth_ptr
);
    ctrl_t         ctrl;
    logic          change;
    logic [DW-1:0] tos_q, sos_q, tos_nxt, sos_nxt;
    logic [DW-1:0] sum_w, cy_w, result;
    logic [$clog2(DEPTH)-1:0] ptr_q;

    stk_decode u_dec (
        .op_valid (op_valid),
        .opcode   (opcode),
        .tos_lsb  (tos_q[0]),
        .ctrl     (ctrl),
        .change   (change)
    );

    stk_units #(.DW(DW)) u_units (
        .tos_i  (tos_q),
        .sos_i  (sos_q),
        .sum_i  (sum_w),
        .sel    (ctrl.sel),
        .result (result)
    );

    stk_adder #(.DW(DW), .CSTEP(CSTEP)) u_add (
        .clk     (clk),
        .rst     (rst),
        .load    (change),
        .a_n     (tos_nxt),
        .b_n     (sos_nxt),
        .sum_o   (sum_w),
        .carry_o (cy_w)
    );

    stk_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .result  (result),
        .tos_q   (tos_q),
        .sos_q   (sos_q),
        .ptr_q   (ptr_q),
        .tos_nxt (tos_nxt),
        .sos_nxt (sos_nxt)
    );

    assign tos       = tos_q;
    assign sos       = sos_q;
    assign depth_ptr = ptr_q;

    logic [DW-1:0] held_w, stack_w;
    assign held_w  = sum_w + cy_w;
    assign stack_w = tos_q + sos_q;

    AST_SUM_CONSERVED: assert property (@(posedge clk) disable iff (rst)
        held_w == stack_w); // R12

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || opcode == OP_NOP || opcode == OP_RSV)
        |=> $stable(tos_q) && $stable(sos_q) && $stable(ptr_q)); // R2

    AST_ADDC_NOPOP: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opcode == OP_ADDC) |=> $stable(sos_q) && $stable(ptr_q)); // R9

    AST_AND_RESULT: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opcode == OP_AND) |=> tos_q == ($past(tos_q) & $past(sos_q))); // R4

    AST_INV_RESULT: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opcode == OP_INV) |=> (tos_q == ~$past(tos_q)) && $stable(sos_q)); // R5
endmodule

// File: tb/stk_alu_test.sv
module stk_alu_test;
    localparam logic [2:0] NOP = 3'd0, DUP = 3'd1, AND_ = 3'd2, XOR_ = 3'd3,
                           INV = 3'd4, ADD = 3'd5, ADDC = 3'd6, RSV = 3'd7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  opcode = 3'd0;
    logic [19:0] tos, sos;
    logic [2:0]  depth_ptr;

    stk_alu uut (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .opcode    (opcode),
        .tos       (tos),
        .sos       (sos),
        .depth_ptr (depth_ptr)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [19:0] tos;
        logic [19:0] sos;
        logic [2:0]  ptr;
        string       tag;
    } exp_t;
    exp_t sb[$];

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Reference model built from the requirements.
    logic [19:0] m_tos, m_sos, m_s, m_c;
    logic [19:0] m_ring [8];
    logic [2:0]  m_ptr;

    function automatic void model_reset();
        m_tos = '0; m_sos = '0; m_s = '0; m_c = '0; m_ptr = '0;
        for (int i = 0; i < 8; i++) m_ring[i] = '0;
    endfunction

    function automatic void model_step(bit v, logic [2:0] op);
        bit wr = 0, push = 0, pop = 0;
        logic [19:0] res = m_tos, n_sos = m_sos, t;
        if (v) begin
            case (op)
                DUP:  push = 1;
                AND_: begin wr = 1; res = m_tos & m_sos; pop = 1; end
                XOR_: begin wr = 1; res = m_tos ^ m_sos; pop = 1; end
                INV:  begin wr = 1; res = ~m_tos; end
                ADD:  begin wr = 1; res = m_s; pop = 1; end
                ADDC: if (m_tos[0]) begin wr = 1; res = m_s; end
                default: ;
            endcase
        end
        if (push) begin
            m_ring[m_ptr + 3'd1] = m_sos;
            n_sos = m_tos;
            m_ptr = m_ptr + 3'd1;
        end else if (pop) begin
            n_sos = m_ring[m_ptr];
            m_ptr = m_ptr - 3'd1;
        end
        if (wr) m_tos = res;
        m_sos = n_sos;
        if (wr || push || pop) begin           // R6
            m_s = m_tos ^ m_sos;
            m_c = (m_tos & m_sos) << 1;
        end else begin                         // R7
            for (int k = 0; k < 4; k++) begin
                t   = m_s ^ m_c;
                m_c = (m_s & m_c) << 1;
                m_s = t;
            end
        end
    endfunction

    task automatic check(string req, logic [19:0] act, logic [19:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: one opcode per cycle, expectation into the scoreboard.
    task automatic issue(bit v, logic [2:0] op, string tag);
        exp_t e;
        @(negedge clk);
        op_valid = v;
        opcode   = op;
        model_step(v, op);
        e.tos = m_tos; e.sos = m_sos; e.ptr = m_ptr; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares each cycle's result.
    always @(posedge clk) begin
        #1;
        if (!rst && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (tos !== e.tos || sos !== e.sos || depth_ptr !== e.ptr) begin
                n_fail++;
                $display("FAIL %s actual tos=%h sos=%h ptr=%0d expected tos=%h sos=%h ptr=%0d",
                         e.tag, tos, sos, depth_ptr, e.tos, e.sos, e.ptr);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; op_valid = 1'b0; opcode = NOP;
        sb.delete();
        model_reset();
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic settle_check(string req, logic [19:0] t, logic [19:0] s, logic [2:0] p);
        @(posedge clk);
        #2;
        check(req, tos, t);
        check(req, sos, s);
        check(req, {17'd0, depth_ptr}, {17'd0, p});
    endtask

    // Leaves TOS=00001, SOS=FFFFF, pointer 1, adder freshly loaded.
    task automatic setup_pair();
        issue(1, INV, "R5 setup");
        issue(1, DUP, "R3 setup");
        issue(1, DUP, "R3 setup");
        repeat (5) issue(1, NOP, "R2 setup");
        issue(1, ADD, "R8 setup");
        issue(1, INV, "R5 setup");
    endtask

    initial begin
        do_reset();
        #1;
        check("R1 tos", tos, 20'h0);
        check("R1 sos", sos, 20'h0);
        check("R1 ptr", {17'd0, depth_ptr}, 20'h0);
        issue(1, ADD, "R1 adder cleared");
        settle_check("R1", 20'h0, 20'h0, 3'd7);

        // Add with zero nops: partial = TOS ^ SOS.
        do_reset();
        setup_pair();
        issue(1, ADD, "R6 R8 zero nops");
        settle_check("R8", 20'hFFFFE, 20'h00000, 3'd0);

        // One nop: four ripple steps.
        do_reset();
        setup_pair();
        issue(1, NOP, "R7 one nop");
        issue(1, ADD, "R7 R8 one nop");
        settle_check("R7", 20'hFFFE0, 20'h00000, 3'd0);

        // Five nops: exact sum, wraps to zero.
        do_reset();
        setup_pair();
        repeat (5) issue(1, NOP, "R7 five nops");
        issue(1, ADD, "R7 R12 five nops");
        settle_check("R12", 20'h00000, 20'h00000, 3'd0);

        // Conditional add taken, then not taken.
        do_reset();
        setup_pair();
        repeat (5) issue(1, NOP, "R9 wait");
        issue(1, ADDC, "R9 taken");
        settle_check("R9", 20'h00000, 20'hFFFFF, 3'd1);
        issue(1, ADDC, "R9 not taken");
        settle_check("R9", 20'h00000, 20'hFFFFF, 3'd1);

        // Reserved opcode and idle strobe act as nops for the adder.
        do_reset();
        setup_pair();
        repeat (5) issue(1, RSV, "R10 reserved");
        issue(1, ADD, "R10 add");
        settle_check("R10", 20'h00000, 20'h00000, 3'd0);
        do_reset();
        setup_pair();
        repeat (5) issue(0, ADD, "R2 strobe low");
        settle_check("R2", 20'h00001, 20'hFFFFF, 3'd1);
        issue(1, ADD, "R2 add");
        settle_check("R2", 20'h00000, 20'h00000, 3'd0);

        // Logic units.
        do_reset();
        setup_pair();
        issue(1, XOR_, "R4 xor");
        settle_check("R4", 20'hFFFFE, 20'h00000, 3'd0);
        do_reset();
        setup_pair();
        issue(1, AND_, "R4 and");
        settle_check("R4", 20'h00001, 20'h00000, 3'd0);

        // Dup copies and pointer wrap.
        do_reset();
        issue(1, INV, "R5 inv");
        settle_check("R5", 20'hFFFFF, 20'h00000, 3'd0);
        repeat (9) issue(1, DUP, "R11 push");
        settle_check("R11", 20'hFFFFF, 20'hFFFFF, 3'd1);
        check("R3 dup copy", sos, tos);
        repeat (10) issue(1, XOR_, "R11 pop");
        issue(0, NOP, "R2 idle");
        repeat (3) @(posedge clk);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule